// File: doc/BRIEF.md
# Operating-Point Change Sequencer

Two cores each post a performance request made of a clock-ratio code and a supply-voltage code. The block keeps one request register per core and merges the two into a single package target. It then walks the package from its present operating point to that target. It drives the PLL ratio and waits for the PLL to report lock. It moves the voltage code one unit at a time with a settle gap between units. The order of these two actions depends on the direction of the move.

For as long as a change runs, the cores are stalled, bus snoops are held off and a busy flag is raised. A request written during a change is not lost. The merged target is compared again once the block is idle, so the latest request is carried out next. If the PLL fails to lock in time, the block raises a sticky error flag and returns to the point it left. It does not retry that failed target until the merged target changes.

Top module: `dvfs_seq`

## Requirements
- R1: When both core requests hold the same ratio and voltage codes, the package settles at exactly that ratio and voltage.
- R2: When the core requests differ, the package target is the larger ratio code and the larger voltage code, each taken on its own.
- R3: On a move to a lower ratio, the ratio output changes first while the voltage code is still at its old value. The voltage code starts to move only after the lock input is seen high.
- R4: On a move to an equal or higher ratio, the voltage code reaches its target first, and only then does the ratio output change.
- R5: The voltage code changes by exactly one unit at a time. Two changes are at least SETTLE+1 clock cycles apart.
- R6: core_stall is high in every cycle of a change and never stays high for more than STALL_MAX consecutive cycles.
- R7: snoop_block and busy are high in exactly the cycles in which core_stall is high.
- R8: A request written while a change is running is held. When that change ends, a new change starts toward the merged target.
- R9: If a write leaves the merged target equal to the present operating point, no change starts and busy stays low.
- R10: If lock is not seen within LOCK_TMO cycles of a ratio change, lock_err is set and stays set until reset. Ratio and voltage return to their values from before the change, and the same target is not retried while the merged target stays unchanged.
- R11: After reset, the ratio output is RST_RATIO, the voltage code is RST_VID, and busy, core_stall, snoop_block and lock_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req0_wr | input | 1 | Write strobe for core 0 request |
| req0_ratio | input | RATIO_W | Core 0 requested ratio code |
| req0_vid | input | VID_W | Core 0 requested voltage code |
| req1_wr | input | 1 | Write strobe for core 1 request |
| req1_ratio | input | RATIO_W | Core 1 requested ratio code |
| req1_vid | input | VID_W | Core 1 requested voltage code |
| pll_lock | input | 1 | PLL lock indication |
| pll_ratio | output | RATIO_W | Ratio driven to the PLL |
| vid | output | VID_W | Voltage code driven to the regulator |
| core_stall | output | 1 | Stalls both cores during a change |
| snoop_block | output | 1 | Holds off bus snoops during a change |
| busy | output | 1 | A change is running |
| lock_err | output | 1 | Sticky PLL lock timeout flag |

## Verification
The bench uses a 5-bit ratio and a 4-bit voltage code, so a full voltage swing is at most 15 steps. It sets SETTLE to 2 and LOCK_TMO to 24. A modelled PLL locks after one to six cycles and can be made to never relock. These values keep full-range ramps, settle-gap timing and the lock-timeout restore path inside a short run. They also let STALL_MAX be set to 200, so the stall bound is checked against real worst-case moves. Random requests from both cores reach both move directions, requests that collapse to the same target, and requests queued behind a running change.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;

  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_RAMP_UP = 3'd1,
    S_RELOCK  = 3'd2,
    S_RAMP_DN = 3'd3,
    S_RESTORE = 3'd4
  } seq_st_e;

  // larger of two unsigned codes
  function automatic int unsigned pick_hi(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // one-unit move of a code toward a goal
  function automatic int unsigned step_toward(input int unsigned cur, input int unsigned goal);
    if (cur < goal) return cur + 1;
    if (cur > goal) return cur - 1;
    return cur;
  endfunction

endpackage

// File: rtl/dvfs_req_merge.sv
module dvfs_req_merge
  import dvfs_pkg::*;
#(
  parameter int RATIO_W   = 6,
  parameter int VID_W     = 6,
  parameter int RST_RATIO = 12,
  parameter int RST_VID   = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr0,
  input  logic [RATIO_W-1:0] ratio0,
  input  logic [VID_W-1:0]   vid0,
  input  logic               wr1,
  input  logic [RATIO_W-1:0] ratio1,
  input  logic [VID_W-1:0]   vid1,
  output logic [RATIO_W-1:0] tgt_ratio,
  output logic [VID_W-1:0]   tgt_vid
);

  logic [RATIO_W-1:0] r0_q, r1_q;
  logic [VID_W-1:0]   v0_q, v1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r0_q <= RATIO_W'(RST_RATIO);
      v0_q <= VID_W'(RST_VID);
      r1_q <= RATIO_W'(RST_RATIO);
      v1_q <= VID_W'(RST_VID);
    end else begin
      if (wr0) begin
        r0_q <= ratio0;
        v0_q <= vid0;
      end
      if (wr1) begin
        r1_q <= ratio1;
        v1_q <= vid1;
      end
    end
  end

  // each field resolved on its own
  assign tgt_ratio = RATIO_W'(pick_hi(int'(r0_q), int'(r1_q)));
  assign tgt_vid   = VID_W'(pick_hi(int'(v0_q), int'(v1_q)));

  // R2
  merge_covers_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_ratio >= r0_q) && (tgt_ratio >= r1_q) && (tgt_vid >= v0_q) && (tgt_vid >= v1_q)
    && ((tgt_ratio == r0_q) || (tgt_ratio == r1_q)));

endmodule

// File: rtl/dvfs_vid_ramp.sv
module dvfs_vid_ramp
  import dvfs_pkg::*;
#(
  parameter int VID_W   = 6,
  parameter int SETTLE  = 4,
  parameter int RST_VID = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VID_W-1:0] goal,
  output logic [VID_W-1:0] vid,
  output logic             at_goal,
  output logic             step_evt
);

  localparam int CNT_W = (SETTLE > 0) ? $clog2(SETTLE + 1) : 1;

  logic [VID_W-1:0] vid_q;
  logic [CNT_W-1:0] cnt_q;
  logic             need_move;

  assign need_move = (vid_q != goal);
  assign step_evt  = need_move && (cnt_q == '0);
  assign at_goal   = !need_move && (cnt_q == '0);
  assign vid       = vid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vid_q <= VID_W'(RST_VID);
      cnt_q <= '0;
    end else if (step_evt) begin
      vid_q <= VID_W'(step_toward(int'(vid_q), int'(goal)));
      cnt_q <= CNT_W'(SETTLE);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R5
  vid_unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_q != $past(vid_q)) |-> ((vid_q == $past(vid_q) + 1'b1) || (vid_q == $past(vid_q) - 1'b1)));

  generate
    if (SETTLE > 0) begin : g_gap
      // R5
      vid_settle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_evt |=> !step_evt);
    end
  endgenerate

endmodule

// File: rtl/dvfs_seq.sv
module dvfs_seq
  import dvfs_pkg::*;
#(
  parameter int RATIO_W   = 6,
  parameter int VID_W     = 6,
  parameter int SETTLE    = 4,
  parameter int LOCK_TMO  = 64,
  parameter int STALL_MAX = 1000,
  parameter int RST_RATIO = 12,
  parameter int RST_VID   = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req0_wr,
  input  logic [RATIO_W-1:0] req0_ratio,
  input  logic [VID_W-1:0]   req0_vid,
  input  logic               req1_wr,
  input  logic [RATIO_W-1:0] req1_ratio,
  input  logic [VID_W-1:0]   req1_vid,
  input  logic               pll_lock,
  output logic [RATIO_W-1:0] pll_ratio,
  output logic [VID_W-1:0]   vid,
  output logic               core_stall,
  output logic               snoop_block,
  output logic               busy,
  output logic               lock_err
);

  localparam int TMO_W = (LOCK_TMO > 1) ? $clog2(LOCK_TMO) : 1;
  localparam int STC_W = $clog2(STALL_MAX + 2);

  seq_st_e            st;
  logic [RATIO_W-1:0] rs_ratio, ratio_q, t_ratio, p_ratio, blk_ratio;
  logic [VID_W-1:0]   rs_vid, goal_q, t_vid, p_vid, blk_vid, vid_w;
  logic               dir_up, err_q, blk_vld;
  logic [TMO_W-1:0]   tmo_q;
  logic               ramp_done, step_evt;

  dvfs_req_merge #(
    .RATIO_W(RATIO_W), .VID_W(VID_W), .RST_RATIO(RST_RATIO), .RST_VID(RST_VID)
  ) u_merge (
    .clk(clk), .rst_n(rst_n),
    .wr0(req0_wr), .ratio0(req0_ratio), .vid0(req0_vid),
    .wr1(req1_wr), .ratio1(req1_ratio), .vid1(req1_vid),
    .tgt_ratio(rs_ratio), .tgt_vid(rs_vid)
  );

  dvfs_vid_ramp #(
    .VID_W(VID_W), .SETTLE(SETTLE), .RST_VID(RST_VID)
  ) u_ramp (
    .clk(clk), .rst_n(rst_n), .goal(goal_q),
    .vid(vid_w), .at_goal(ramp_done), .step_evt(step_evt)
  );

  // named events for the checks below
  logic tgt_eq_cur, tgt_eq_blk, start_evt, lock_ok_evt, lock_tmo_evt;
  assign tgt_eq_cur   = (rs_ratio == ratio_q) && (rs_vid == vid_w);
  assign tgt_eq_blk   = (rs_ratio == blk_ratio) && (rs_vid == blk_vid);
  assign start_evt    = (st == S_IDLE) && !tgt_eq_cur && !(blk_vld && tgt_eq_blk);
  assign lock_ok_evt  = (st == S_RELOCK) && pll_lock;
  assign lock_tmo_evt = (st == S_RELOCK) && !pll_lock && (tmo_q == TMO_W'(LOCK_TMO - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      ratio_q   <= RATIO_W'(RST_RATIO);
      goal_q    <= VID_W'(RST_VID);
      t_ratio   <= RATIO_W'(RST_RATIO);
      t_vid     <= VID_W'(RST_VID);
      p_ratio   <= RATIO_W'(RST_RATIO);
      p_vid     <= VID_W'(RST_VID);
      blk_ratio <= RATIO_W'(RST_RATIO);
      blk_vid   <= VID_W'(RST_VID);
      blk_vld   <= 1'b0;
      dir_up    <= 1'b0;
      tmo_q     <= '0;
      err_q     <= 1'b0;
    end else begin
      if (blk_vld && !tgt_eq_blk) blk_vld <= 1'b0;
      unique case (st)
        S_IDLE: if (start_evt) begin
          t_ratio <= rs_ratio;
          t_vid   <= rs_vid;
          p_ratio <= ratio_q;
          p_vid   <= vid_w;
          tmo_q   <= '0;
          if (rs_ratio < ratio_q) begin
            dir_up  <= 1'b0;
            ratio_q <= rs_ratio;
            st      <= S_RELOCK;
          end else begin
            dir_up  <= 1'b1;
            goal_q  <= rs_vid;
            st      <= S_RAMP_UP;
          end
        end
        S_RAMP_UP: if (ramp_done) begin
          ratio_q <= t_ratio;
          tmo_q   <= '0;
          st      <= S_RELOCK;
        end
        S_RELOCK: begin
          if (pll_lock) begin
            if (dir_up) begin
              st <= S_IDLE;
            end else begin
              goal_q <= t_vid;
              st     <= S_RAMP_DN;
            end
          end else if (lock_tmo_evt) begin
            err_q     <= 1'b1;
            blk_vld   <= 1'b1;
            blk_ratio <= t_ratio;
            blk_vid   <= t_vid;
            ratio_q   <= p_ratio;
            goal_q    <= p_vid;
            st        <= S_RESTORE;
          end else begin
            tmo_q <= tmo_q + 1'b1;
          end
        end
        S_RAMP_DN, S_RESTORE: if (ramp_done) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign pll_ratio   = ratio_q;
  assign vid         = vid_w;
  assign busy        = (st != S_IDLE);
  assign core_stall  = busy;
  assign snoop_block = busy;
  assign lock_err    = err_q;

  // stall length watch
  logic [STC_W-1:0] stall_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stall_cnt <= '0;
    else if (busy) stall_cnt <= (stall_cnt == STC_W'(STALL_MAX + 1)) ? stall_cnt : stall_cnt + 1'b1;
    else stall_cnt <= '0;
  end

  // R6
  stall_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (stall_cnt < STC_W'(STALL_MAX)));

  // R3
  relock_vid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RELOCK) |=> (vid_w == $past(vid_w)));

  // R4
  ramp_up_ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_RAMP_UP) && !ramp_done) |=> (ratio_q == $past(ratio_q)));

  // R9
  no_spurious_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_IDLE) && tgt_eq_cur) |=> (st == S_IDLE));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  // R10
  restore_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_tmo_evt |=> (ratio_q == p_ratio) && (st == S_RESTORE));

endmodule

// File: tb/dvfs_seq_tb.sv
module dvfs_seq_tb;
  localparam int RW = 5, VW = 4, SET = 2, TMO = 24, SMAX = 200;
  localparam int RR = 10, RV = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req0_wr = 0, req1_wr = 0, pll_lock = 1'b1;
  logic [RW-1:0] req0_ratio = '0, req1_ratio = '0, pll_ratio;
  logic [VW-1:0] req0_vid = '0, req1_vid = '0, vid;
  logic core_stall, snoop_block, busy, lock_err;

  always #5 clk = ~clk;

  dvfs_seq #(.RATIO_W(RW), .VID_W(VW), .SETTLE(SET), .LOCK_TMO(TMO),
             .STALL_MAX(SMAX), .RST_RATIO(RR), .RST_VID(RV)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req0_wr(req0_wr), .req0_ratio(req0_ratio), .req0_vid(req0_vid),
    .req1_wr(req1_wr), .req1_ratio(req1_ratio), .req1_vid(req1_vid),
    .pll_lock(pll_lock), .pll_ratio(pll_ratio), .vid(vid),
    .core_stall(core_stall), .snoop_block(snoop_block), .busy(busy), .lock_err(lock_err));

  int tests = 0, fails = 0;
  bit done = 0;
  int m_r0 = RR, m_v0 = RV, m_r1 = RR, m_v1 = RV;
  bit lock_dead = 0;

  function automatic int hi(input int a, input int b);
    return (a >= b) ? a : b;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // PLL lock model
  int lock_cnt = 0;
  logic [RW-1:0] seen_ratio = RR[RW-1:0];
  always @(negedge clk) begin
    if (rst_n) begin
      if (pll_ratio != seen_ratio) begin
        seen_ratio = pll_ratio;
        pll_lock = 1'b0;
        lock_cnt = 1 + ($urandom % 6);
      end else if (!lock_dead) begin
        if (lock_cnt > 0) lock_cnt--;
        else pll_lock = 1'b1;
      end
    end
  end

  // monitor
  int busy_rises = 0, stall_len = 0, max_stall = 0, gap = 0;
  int step_bad = 0, settle_bad = 0, flag_bad = 0, vid_nolock = 0;
  int first_chg = 0, ratio_chg_vid = 0;
  logic [RW-1:0] pr = RR[RW-1:0];
  logic [VW-1:0] pv = RV[VW-1:0];
  bit pb = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if ((snoop_block !== core_stall) || (busy !== core_stall)) flag_bad++;
      if (busy && !pb) begin
        busy_rises++; stall_len = 0; gap = 1000; first_chg = 0; ratio_chg_vid = -1;
      end
      if (busy) begin
        stall_len++;
        if (stall_len > max_stall) max_stall = stall_len;
        if (pll_ratio != pr && first_chg == 0) first_chg = 1;
        if (pll_ratio != pr && ratio_chg_vid < 0) ratio_chg_vid = int'(vid);
        if (vid != pv) begin
          if (!((int'(vid) == int'(pv) + 1) || (int'(vid) + 1 == int'(pv)))) step_bad++;
          if (gap < SET) settle_bad++;
          if (!pll_lock && !lock_dead) vid_nolock++;
          if (first_chg == 0) first_chg = 2;
          gap = 0;
        end else gap++;
      end
      pr = pll_ratio; pv = vid; pb = busy;
    end
  end

  task automatic wr(input int c, input int r, input int v);
    @(negedge clk);
    if (c == 0) begin req0_wr = 1; req0_ratio = RW'(r); req0_vid = VW'(v); m_r0 = r; m_v0 = v; end
    else begin req1_wr = 1; req1_ratio = RW'(r); req1_vid = VW'(v); m_r1 = r; m_v1 = v; end
    @(negedge clk);
    req0_wr = 0; req1_wr = 0;
  endtask

  task automatic wait_done();
    int b = busy_rises;
    for (int i = 0; i < 10 && busy_rises == b; i++) @(negedge clk);
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
  endtask

  task automatic check_move(input string tag);
    int cr = int'(pll_ratio), cv = int'(vid);
    int er = hi(m_r0, m_r1), ev = hi(m_v0, m_v1);
    int b = busy_rises;
    if (er == cr && ev == cv) begin
      repeat (12) @(negedge clk);
      chk(busy_rises == b, "R9 no start", busy_rises - b, 0);
    end else begin
      step_bad = 0; settle_bad = 0; max_stall = 0; flag_bad = 0; vid_nolock = 0;
      wait_done();
      chk(busy_rises == b + 1, {tag, " R6 one change"}, busy_rises - b, 1);
      if (lock_dead) begin
        chk(int'(pll_ratio) == cr, "R10 ratio restored", int'(pll_ratio), cr);
        chk(int'(vid) == cv, "R10 vid restored", int'(vid), cv);
        chk(lock_err == 1'b1, "R10 err set", lock_err, 1);
      end else begin
        chk(int'(pll_ratio) == er, {tag, " R1 R2 ratio"}, int'(pll_ratio), er);
        chk(int'(vid) == ev, {tag, " R1 R2 vid"}, int'(vid), ev);
        if (er < cr) begin
          chk(first_chg == 1 && ratio_chg_vid == cv, "R3 ratio first", ratio_chg_vid, cv);
          chk(vid_nolock == 0, "R3 vid after lock", vid_nolock, 0);
        end else if (er != cr) begin
          chk(ratio_chg_vid == ev, "R4 vid first", ratio_chg_vid, ev);
        end
      end
      chk(step_bad == 0, "R5 unit step", step_bad, 0);
      chk(settle_bad == 0, "R5 settle gap", settle_bad, 0);
      chk(max_stall > 0 && max_stall <= SMAX, "R6 stall bound", max_stall, SMAX);
      chk(flag_bad == 0, "R7 flags match", flag_bad, 0);
    end
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R6 act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int b0;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11
    chk(int'(pll_ratio) == RR, "R11 ratio", int'(pll_ratio), RR);
    chk(int'(vid) == RV, "R11 vid", int'(vid), RV);
    chk({busy, core_stall, snoop_block, lock_err} == 4'b0, "R11 flags",
        int'({busy, core_stall, snoop_block, lock_err}), 0);

    wr(0, 14, 9);  check_move("up");
    wr(1, 14, 9);  check_move("R1 same");
    wr(0, 8, 4);   check_move("R9 hidden");
    wr(1, 8, 4);   check_move("R3 down");
    wr(0, 12, 3);  check_move("R2 a");
    wr(1, 9, 7);   check_move("R2 b");

    // R8 queued request
    b0 = busy_rises;
    wr(0, 20, 12);
    for (int i = 0; i < 10 && !busy; i++) @(negedge clk);
    wr(1, 25, 14);
    chk(busy == 1'b1, "R8 still busy", busy, 1);
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    wait_done();
    chk(busy_rises == b0 + 2, "R8 second change", busy_rises - b0, 2);
    chk(int'(pll_ratio) == 25 && int'(vid) == 14, "R8 final", int'(pll_ratio), 25);

    // R10 lock timeout on an up move
    lock_dead = 1;
    wr(0, 28, 15); check_move("R10");
    b0 = busy_rises;
    repeat (15) @(negedge clk);
    chk(busy_rises == b0, "R10 no retry", busy_rises - b0, 0);
    lock_dead = 0;
    repeat (10) @(negedge clk);
    wr(0, 3, 2);   check_move("R9 after err");
    wr(1, 3, 2);   check_move("R3 after err");
    chk(lock_err == 1'b1, "R10 sticky", lock_err, 1);

    for (int i = 0; i < 30; i++) begin
      wr($urandom % 2, $urandom % 32, $urandom % 16);
      check_move("rand");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule